// File: doc/BRIEF.md
# Eight-bit Load Instruction Executor

This block runs the byte-sized load group of a small 8-bit processor. It holds seven working registers (B, C, D, E, H, L, A) and fetches instructions from a byte-wide memory port, starting at address zero after reset. It handles two instruction kinds. A register copy moves one operand into another. An immediate load places the constant that follows the opcode into a destination. Either operand of a copy can be the memory byte at the 16-bit address formed with H as the high byte and L as the low byte. The destination of an immediate load can be that memory byte too.

Each clock cycle is one machine cycle and makes at most one memory access. `instr_done` pulses in the last cycle of every load. An opcode outside the load groups raises `unsupported` for one cycle and changes nothing. The memory-to-memory copy code stops the sequencer and raises `halt` until reset. Memory is modelled as combinational: `mem_rdata` must reflect `mem_addr` in the same cycle.

Top module: `ldx_exec`

## Requirements
- R1: An opcode of the form 01dddsss (bits 5:3 destination, bits 2:0 source), with neither field 110, copies the source register into the destination register in one cycle, during which `instr_done` is high.
- R2: Operand codes select registers as B=000, C=001, D=010, E=011, H=100, L=101, A=111; code 110 selects the memory byte at address {H,L}.
- R3: A copy with source code 110 takes two cycles; the second reads address {H,L} and writes the byte into the destination register.
- R4: A copy with destination code 110 takes two cycles; the second writes the source register to address {H,L} with `mem_wr` high.
- R5: Opcode 0x76 performs no load. From the next cycle `halt` stays high until reset, and neither memory strobe nor `instr_done` is raised.
- R6: An immediate load 00ddd110 followed by a constant byte writes the constant into register ddd in two cycles, and the program counter advances past both bytes.
- R7: An immediate load with ddd=110 takes three cycles; the third writes the constant to address {H,L}.
- R8: No cycle has both `mem_rd` and `mem_wr` high. Each opcode or constant fetch reads at the program counter, and the program counter then advances by one.
- R9: Any other opcode raises `unsupported` for its single fetch cycle without `instr_done`, leaves registers and memory unchanged, and fetching resumes at the next byte.
- R10: While `rst_n` is low at a clock edge, all registers and the program counter clear to zero and the sequencer returns to opcode fetch.
- R11: Opcode 0x45 copies L into B, and the byte pair 0x26 0xA6 writes 0xA6 into H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one machine cycle per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_rdata | input | 8 | Byte read from `mem_addr` in the same cycle |
| mem_addr | output | 16 | Memory address for the current cycle |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte to write when `mem_wr` is high |
| instr_done | output | 1 | High in the final cycle of each load |
| unsupported | output | 1 | High in the fetch cycle of an opcode outside the load groups |
| halt | output | 1 | Sticky stop indication after opcode 0x76 |

## Verification
The register file has no read port, so register contents can only be observed through the memory write path. Every program therefore ends by storing the registers of interest through {H,L} copies before it halts. The hardest case is a load that changes H or L itself, such as the 0x26 0xA6 pair. Its only visible effect is the address of a later store, so the bench checks the full 16-bit write address as well as the data. Latency requirements are checked by counting the active cycles to halt and comparing the count with the sum of the per-instruction cycle counts.

// File: rtl/ldx_pkg.sv
// Shared types for the load executor.
// Assumes 8-bit opcodes with 3-bit operand fields at bits 5:3 and 2:0.
package ldx_pkg;

    localparam int          CODE_W   = 3;
    localparam logic [2:0]  CODE_MEM = 3'b110;
    localparam logic [7:0]  OP_STOP  = 8'h76;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_IMM   = 3'd1,
        ST_MRD   = 3'd2,
        ST_MWR   = 3'd3,
        ST_HALT  = 3'd4
    } seq_state_t;

    typedef struct packed {
        logic              reg_copy;
        logic              mem_src;
        logic              mem_dst;
        logic              imm;
        logic              stop;
        logic              unsup;
        logic [CODE_W-1:0] dst;
        logic [CODE_W-1:0] src;
    } dec_t;

endpackage

// File: rtl/ldx_decode.sv
// Opcode classifier: splits a fetched byte into the load kinds the
// sequencer handles. Purely combinational; assumes an 8-bit opcode.
module ldx_decode
    import ldx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] opcode,
    output dec_t              dec
);

    localparam int SRC_LO = 0;
    localparam int DST_LO = SRC_LO + CODE_W;
    localparam int GRP_LO = DST_LO + CODE_W;

    logic [1:0]        grp;
    logic [CODE_W-1:0] f_dst;
    logic [CODE_W-1:0] f_src;

    assign grp   = opcode[GRP_LO +: 2];
    assign f_dst = opcode[DST_LO +: CODE_W];
    assign f_src = opcode[SRC_LO +: CODE_W];

    // Classify the opcode into exactly one kind
    always_comb begin
        dec          = '0;
        dec.dst      = f_dst;
        dec.src      = f_src;
        if (grp == 2'b01) begin
            if (opcode == DATA_W'(OP_STOP))  dec.stop     = 1'b1;
            else if (f_src == CODE_MEM)      dec.mem_src  = 1'b1;
            else if (f_dst == CODE_MEM)      dec.mem_dst  = 1'b1;
            else                             dec.reg_copy = 1'b1;
        end else if (grp == 2'b00 && f_src == CODE_MEM) begin
            dec.imm = 1'b1;
        end else begin
            dec.unsup = 1'b1;
        end
    end

endmodule

// File: rtl/ldx_regfile.sv
// Working register bank indexed by operand code. The memory code has no
// storage and reads as zero. One write port, one selectable read port,
// plus dedicated H and L taps for address formation.
module ldx_regfile
    import ldx_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int NUM_CODES = 8,
    parameter int H_CODE    = 4,
    parameter int L_CODE    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CODE_W-1:0] wsel,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CODE_W-1:0] rsel,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] h_q,
    output logic [DATA_W-1:0] l_q
);

    logic [NUM_CODES-1:0][DATA_W-1:0] bank;

    for (genvar i = 0; i < NUM_CODES; i++) begin : g_slot
        if (i == int'(CODE_MEM)) begin : g_mem
            assign bank[i] = '0;
        end else begin : g_reg
            logic [DATA_W-1:0] q;
            // Hold one register; clear on reset, load when selected
            always_ff @(posedge clk) begin
                if (!rst_n)                               q <= '0;
                else if (we && wsel == CODE_W'(i))        q <= wdata;
            end
            assign bank[i] = q;
        end
    end

    assign rdata = bank[rsel];
    assign h_q   = bank[H_CODE];
    assign l_q   = bank[L_CODE];

endmodule

// File: rtl/ldx_sequencer.sv
// Machine-cycle sequencer: fetches opcodes and constants, performs the
// indirect read or write through {H,L}, and drives register writeback.
// Assumes combinational memory: mem_rdata is valid for mem_addr in-cycle.
module ldx_sequencer
    import ldx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  dec_t              dec,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] src_data,
    input  logic [ADDR_W-1:0] hl_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rf_we,
    output logic [CODE_W-1:0] rf_wsel,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              instr_done,
    output logic              unsupported,
    output logic              halt,
    output logic [ADDR_W-1:0] pc_now
);

    seq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] pc_q;
    logic              pc_inc;
    logic [CODE_W-1:0] dst_q;
    logic              dst_load;
    logic [DATA_W-1:0] hold_q, hold_d;
    logic              hold_load;

    // Next-state, memory strobes and writeback controls per machine cycle
    always_comb begin
        state_d     = state_q;
        mem_addr    = pc_q;
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        mem_wdata   = hold_q;
        rf_we       = 1'b0;
        rf_wsel     = dec.dst;
        rf_wdata    = src_data;
        instr_done  = 1'b0;
        unsupported = 1'b0;
        pc_inc      = 1'b0;
        dst_load    = 1'b0;
        hold_load   = 1'b0;
        hold_d      = src_data;
        unique case (state_q)
            ST_FETCH: begin
                mem_rd = 1'b1;
                pc_inc = 1'b1;
                if (dec.reg_copy) begin
                    rf_we      = 1'b1;
                    instr_done = 1'b1;
                end else if (dec.mem_src) begin
                    dst_load = 1'b1;
                    state_d  = ST_MRD;
                end else if (dec.mem_dst) begin
                    hold_load = 1'b1;
                    state_d   = ST_MWR;
                end else if (dec.imm) begin
                    dst_load = 1'b1;
                    state_d  = ST_IMM;
                end else if (dec.stop) begin
                    state_d = ST_HALT;
                end else begin
                    unsupported = 1'b1;
                end
            end
            ST_IMM: begin
                mem_rd = 1'b1;
                pc_inc = 1'b1;
                if (dst_q == CODE_MEM) begin
                    hold_load = 1'b1;
                    hold_d    = mem_rdata;
                    state_d   = ST_MWR;
                end else begin
                    rf_we      = 1'b1;
                    rf_wsel    = dst_q;
                    rf_wdata   = mem_rdata;
                    instr_done = 1'b1;
                    state_d    = ST_FETCH;
                end
            end
            ST_MRD: begin
                mem_addr   = hl_addr;
                mem_rd     = 1'b1;
                rf_we      = 1'b1;
                rf_wsel    = dst_q;
                rf_wdata   = mem_rdata;
                instr_done = 1'b1;
                state_d    = ST_FETCH;
            end
            ST_MWR: begin
                mem_addr   = hl_addr;
                mem_wr     = 1'b1;
                instr_done = 1'b1;
                state_d    = ST_FETCH;
            end
            default: begin
                state_d = ST_HALT;
            end
        endcase
    end

    // Sequencer state and program counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FETCH;
            pc_q    <= '0;
        end else begin
            state_q <= state_d;
            if (pc_inc) pc_q <= pc_q + 1'b1;
        end
    end

    // Latched destination code and pending write byte for later cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_q  <= '0;
            hold_q <= '0;
        end else begin
            if (dst_load)  dst_q  <= dec.dst;
            if (hold_load) hold_q <= hold_d;
        end
    end

    assign halt   = (state_q == ST_HALT);
    assign pc_now = pc_q;

endmodule

// File: rtl/ldx_exec.sv
// Top of the load executor: decoder on the memory read bus, register
// bank, and machine-cycle sequencer. One memory access per clock.
module ldx_exec
    import ldx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              instr_done,
    output logic              unsupported,
    output logic              halt
);

    dec_t              dec;
    logic              rf_we;
    logic [CODE_W-1:0] rf_wsel;
    logic [DATA_W-1:0] rf_wdata;
    logic [DATA_W-1:0] src_data;
    logic [DATA_W-1:0] h_q, l_q;
    logic [ADDR_W-1:0] hl_addr;
    logic [ADDR_W-1:0] pc_now;

    assign hl_addr = ADDR_W'({h_q, l_q});

    ldx_decode #(.DATA_W(DATA_W)) u_decode (
        .opcode (mem_rdata),
        .dec    (dec)
    );

    ldx_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .wsel  (rf_wsel),
        .wdata (rf_wdata),
        .rsel  (dec.src),
        .rdata (src_data),
        .h_q   (h_q),
        .l_q   (l_q)
    );

    ldx_sequencer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec         (dec),
        .mem_rdata   (mem_rdata),
        .src_data    (src_data),
        .hl_addr     (hl_addr),
        .mem_addr    (mem_addr),
        .mem_rd      (mem_rd),
        .mem_wr      (mem_wr),
        .mem_wdata   (mem_wdata),
        .rf_we       (rf_we),
        .rf_wsel     (rf_wsel),
        .rf_wdata    (rf_wdata),
        .instr_done  (instr_done),
        .unsupported (unsupported),
        .halt        (halt),
        .pc_now      (pc_now)
    );

endmodule

// File: rtl/ldx_exec_checker.sv
// Protocol checker for the load executor, attached by bind.
// Assumes the same parameters as the bound instance.
module ldx_exec_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              instr_done,
    input logic              unsupported,
    input logic              halt,
    input logic [ADDR_W-1:0] hl_addr
);

    assert_one_access_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_write_at_hl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> mem_addr == hl_addr);

    assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> halt);

    assert_halt_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        halt |-> (!mem_rd && !mem_wr && !instr_done));

    assert_unsup_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (!instr_done && !mem_wr && !halt));

    assert_unsup_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |=> (mem_rd && mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_reset_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mem_rd && mem_addr == '0 && !halt));

endmodule

bind ldx_exec ldx_exec_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .instr_done  (instr_done),
    .unsupported (unsupported),
    .halt        (halt),
    .hl_addr     (hl_addr)
);

// File: tb/ldx_exec_bench.sv
`timescale 1ns/1ps
// Directed bench: each task loads a short program, runs it to halt,
// and checks memory writes, cycle totals and strobes.
module ldx_exec_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mem_rdata;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic        instr_done, unsupported, halt;

    logic [7:0]  mem [256];
    logic [15:0] wa [32];
    logic [7:0]  wd [32];
    int          wn, un, both_cnt;
    int          n_chk = 0, n_fail = 0;
    int          lp;
    int          active;
    bit          logging = 1'b0;

    always #2.5 clk = ~clk;

    ldx_exec u_ldx_exec (
        .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .instr_done(instr_done), .unsupported(unsupported), .halt(halt)
    );

    assign mem_rdata = mem[mem_addr[7:0]];

    // Memory model writes and activity log, sampled away from the edge
    always @(negedge clk) begin
        if (logging && rst_n) begin
            if (mem_wr) begin
                mem[mem_addr[7:0]] = mem_wdata;
                if (wn < 32) begin wa[wn] = mem_addr; wd[wn] = mem_wdata; end
                wn++;
            end
            if (unsupported) un++;
            if (mem_rd && mem_wr) both_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic emit(input logic [7:0] b);
        mem[lp] = b;
        lp++;
    endtask

    task automatic new_prog();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        lp = 0;
    endtask

    // Reset, release, and count active cycles up to halt
    task automatic run_prog();
        logging = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        wn = 0; un = 0; both_cnt = 0;
        logging = 1'b1;
        rst_n = 1'b1;
        active = 0;
        while (!halt && active < 400) begin
            active++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        new_prog();
        emit(8'h70); emit(8'h71); emit(8'h72); emit(8'h73);
        emit(8'h74); emit(8'h75); emit(8'h77); emit(8'h76);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 fetch addr in reset", int'(mem_addr), 0);
        chk("R10 halt low in reset", int'(halt), 0);
        run_prog();
        chk("R10 write count", wn, 7);
        for (int i = 0; i < 7; i++) begin
            chk("R10 cleared register value", int'(wd[i]), 0);
            chk("R4 write addr at HL=0", int'(wa[i]), 0);
        end
        chk("R4 cycles 7 stores + stop", active, 15);
    endtask

    task automatic t_immediate();
        new_prog();
        emit(8'h06); emit(8'h11); emit(8'h0E); emit(8'h22);
        emit(8'h16); emit(8'h33); emit(8'h1E); emit(8'h44);
        emit(8'h3E); emit(8'h55); emit(8'h26); emit(8'h00);
        emit(8'h2E); emit(8'hC0);
        emit(8'h70); emit(8'h71); emit(8'h72); emit(8'h73);
        emit(8'h77); emit(8'h74); emit(8'h75); emit(8'h76);
        run_prog();
        chk("R6 write count", wn, 7);
        chk("R2 B", int'(wd[0]), 'h11);
        chk("R2 C", int'(wd[1]), 'h22);
        chk("R2 D", int'(wd[2]), 'h33);
        chk("R2 E", int'(wd[3]), 'h44);
        chk("R2 A", int'(wd[4]), 'h55);
        chk("R2 H", int'(wd[5]), 'h00);
        chk("R2 L", int'(wd[6]), 'hC0);
        chk("R4 store addr", int'(wa[0]), 'h00C0);
        chk("R6 cycles", active, 29);
    endtask

    task automatic t_copy();
        new_prog();
        emit(8'h3E); emit(8'h5A);
        emit(8'h47); emit(8'h48); emit(8'h51); emit(8'h5A);
        emit(8'h26); emit(8'h00); emit(8'h2E); emit(8'hC8);
        emit(8'h70); emit(8'h71); emit(8'h72); emit(8'h73);
        emit(8'h2E); emit(8'h99); emit(8'h45);
        emit(8'h2E); emit(8'hC9); emit(8'h70); emit(8'h76);
        run_prog();
        chk("R1 write count", wn, 5);
        for (int i = 0; i < 4; i++) chk("R1 copy chain value", int'(wd[i]), 'h5A);
        chk("R11 0x45 copies L into B", int'(wd[4]), 'h99);
        chk("R11 store addr", int'(wa[4]), 'h00C9);
        chk("R1 one-cycle copies in total", active, 26);
    endtask

    task automatic t_mem_src();
        new_prog();
        mem[8'hD0] = 8'h3C;
        emit(8'h26); emit(8'h00); emit(8'h2E); emit(8'hD0);
        emit(8'h7E); emit(8'h2E); emit(8'hD1); emit(8'h77);
        emit(8'h56); emit(8'h2E); emit(8'hD2); emit(8'h72); emit(8'h76);
        run_prog();
        chk("R3 write count", wn, 2);
        chk("R3 A from memory", int'(wd[0]), 'h3C);
        chk("R3 D from memory", int'(wd[1]), 'h3C);
        chk("R3 addr", int'(wa[1]), 'h00D2);
        chk("R3 cycles", active, 17);
    endtask

    task automatic t_imm_mem();
        new_prog();
        emit(8'h26); emit(8'h00); emit(8'h2E); emit(8'hE0);
        emit(8'h36); emit(8'h7B); emit(8'h76);
        run_prog();
        chk("R7 write count", wn, 1);
        chk("R7 data", int'(wd[0]), 'h7B);
        chk("R7 addr", int'(wa[0]), 'h00E0);
        chk("R7 cycles", active, 8);
    endtask

    task automatic t_h_load();
        new_prog();
        emit(8'h26); emit(8'hA6); emit(8'h2E); emit(8'h10);
        emit(8'h74); emit(8'h76);
        run_prog();
        chk("R11 write count", wn, 1);
        chk("R11 H value", int'(wd[0]), 'hA6);
        chk("R11 addr uses new H", int'(wa[0]), 'hA610);
        chk("R6 cycles", active, 7);
    endtask

    task automatic t_unsup();
        new_prog();
        emit(8'h2E); emit(8'hF0);
        emit(8'h00); emit(8'hC3); emit(8'h80); emit(8'h3F);
        emit(8'h70); emit(8'h76);
        run_prog();
        chk("R9 unsupported pulses", un, 4);
        chk("R9 write count", wn, 1);
        chk("R9 B untouched", int'(wd[0]), 0);
        chk("R9 L untouched addr", int'(wa[0]), 'h00F0);
        chk("R8 pc steps one per fetch", active, 9);
    endtask

    task automatic t_halt();
        int busy = 0;
        chk("R5 halt raised", int'(halt), 1);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (mem_rd || mem_wr || instr_done || !halt) busy++;
        end
        chk("R5 quiet while halted", busy, 0);
        chk("R8 never read and write together", both_cnt, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_immediate();
                t_copy();
                t_mem_src();
                t_imm_mem();
                t_h_load();
                t_unsup();
                t_halt();
            end
            begin
                repeat (20000) @(negedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule